// File: doc/BRIEF.md
# Ethernet Collision Backoff Controller

This block is the exception branch of a shared-medium MAC control state machine. When the transmitter reports a collision in half-duplex Ethernet operation, the controller drives a jam burst and bumps the attempt count. It then draws a truncated binary exponential backoff from a free-running LFSR and waits that many slot times. At the end it pulses a retry grant and returns to idle. Once too many attempts have been made it gives up, pulses a failure and clears the count.

Every completed frame is followed by an interframe gap. During the gap the transmit-allow output is held low. When the alternate serial-bus link mode is selected, collisions play no part. A link-side bus reset request instead moves the controller into a bus-reset state, which it holds until the reset is acknowledged. Each exception sequence ends with a one-cycle `done_o` pulse, so the surrounding controller can move on.

Top module: `collision_backoff_ctrl`

## Requirements
- R1: After reset, `tx_allow_o` is 1, `attempt_o` is 0, and `jam_o`, `retry_o`, `fail_o`, `bus_reset_o` and `done_o` are 0.
- R2: When `col_i` is sampled high while idle, with `serial_mode_i`=0 and `half_duplex_i`=1, `jam_o` is high for exactly JAM_CYC (default 8) consecutive cycles, starting with the next cycle.
- R3: `attempt_o` holds its old value during the first cycle after the jam and shows the old value plus one from the cycle after that.
- R4: The chosen backoff r, shown on `backoff_slots_o`, satisfies r < 2^min(attempt, BACKOFF_CAP), where BACKOFF_CAP defaults to 10.
- R5: On a retry, `retry_o` and `done_o` are high together for one cycle. That cycle comes 4 + r*SLOT_CYC cycles after the last jam cycle. The cycle after it, `tx_allow_o` is 1 again.
- R6: The collision that brings the attempt count to ATTEMPT_LIMIT (default 16) gives no backoff. `fail_o` and `done_o` are high together for one cycle, 2 cycles after the last jam cycle. From the next cycle `attempt_o` is 0.
- R7: A `frame_done_i` pulse sampled while idle holds `tx_allow_o` low for exactly IFG_CYC (default 24) cycles. `done_o` is high in the last of those cycles, and `attempt_o` is 0 afterwards.
- R8: With `half_duplex_i`=0, a collision while idle is ignored: `jam_o` stays 0 and `tx_allow_o` stays 1.
- R9: With `serial_mode_i`=1, `col_i` is ignored. A `bus_reset_req_i` sampled while idle raises `bus_reset_o` from the next cycle. `bus_reset_o` stays high until the cycle in which `bus_reset_done_i` is seen; `done_o` is high in that cycle. Afterwards `attempt_o` is 0.
- R10: While the controller is not idle, it ignores `col_i`, `frame_done_i` and `bus_reset_req_i`. For example, a collision during an interframe gap neither raises `jam_o` nor lengthens the gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| serial_mode_i | input | 1 | 1 selects the serial-bus link mode, 0 selects Ethernet |
| half_duplex_i | input | 1 | 1 selects half duplex in Ethernet mode |
| col_i | input | 1 | Collision indication |
| frame_done_i | input | 1 | A frame finished on the medium |
| bus_reset_req_i | input | 1 | Link asks for a bus reset (serial-bus mode) |
| bus_reset_done_i | input | 1 | Bus reset and identification are complete |
| tx_allow_o | output | 1 | Controller is idle; a transmission may start |
| jam_o | output | 1 | Jam pattern is being sent |
| retry_o | output | 1 | Backoff is over; the frame may be retried |
| fail_o | output | 1 | Attempt limit reached; the frame is dropped |
| bus_reset_o | output | 1 | Bus-reset state is active |
| done_o | output | 1 | Last cycle of an exception sequence |
| attempt_o | output | ATT_W (5) | Current attempt count |
| backoff_slots_o | output | BACKOFF_CAP (10) | Backoff chosen for the latest retry, in slot times |

## Verification
The assertions assume that the mode inputs stay constant while an exception sequence is in progress. They also assume that `bus_reset_done_i` is asserted only while a bus reset is pending. The stimulus changes `serial_mode_i` and `half_duplex_i` only while the controller is idle, and it raises `bus_reset_done_i` only after `bus_reset_o` has been seen high. Because the backoff value is random, the bench reads it back from `backoff_slots_o`. It then checks both the range that the attempt count allows and the exact cycle distance to the retry grant. The slot time is shortened by a parameter so that sixteen attempts fit in the run.

// File: rtl/cbo_pkg.sv
package cbo_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_JAM,
    ST_INCR,
    ST_CALC,
    ST_WAIT,
    ST_RETRY,
    ST_GIVEUP,
    ST_IFG,
    ST_BUSRST
  } cbo_state_e;
endpackage

// File: rtl/cbo_lfsr.sv
module cbo_lfsr #(
  parameter int unsigned WIDTH   = 16,
  parameter int unsigned OUT_W   = 10,
  parameter logic [WIDTH-1:0] TAPS = 16'hB400,
  parameter logic [WIDTH-1:0] SEED = 16'hACE1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [OUT_W-1:0] rnd_o
);
  logic [WIDTH-1:0] state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEED;
    else if (state_q[0]) state_q <= (state_q >> 1) ^ TAPS;
    else state_q <= state_q >> 1;
  end

  assign rnd_o = state_q[OUT_W-1:0];

  // all-zero state would lock the generator
  a_r4_lfsr_alive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != '0);
endmodule

// File: rtl/cbo_backoff_pick.sv
module cbo_backoff_pick #(
  parameter int unsigned ATT_W = 5,
  parameter int unsigned CAP   = 10
) (
  input  logic [ATT_W-1:0] attempt_i,
  input  logic [CAP-1:0]   rnd_i,
  output logic [CAP-1:0]   slots_o
);
  logic [CAP-1:0] mask;

  // bit i allowed once attempt exceeds i: width = min(attempt, CAP)
  for (genvar i = 0; i < CAP; i++) begin : g_mask
    assign mask[i] = (attempt_i > ATT_W'(i));
  end

  assign slots_o = rnd_i & mask;
endmodule

// File: rtl/cbo_slot_timer.sv
module cbo_slot_timer #(
  parameter int unsigned SLOT_CYC = 128,
  parameter int unsigned SLOTS_W  = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [SLOTS_W-1:0] slots_i,
  input  logic               run_i,
  output logic               expired_o
);
  localparam int unsigned CYC_W = $clog2(SLOT_CYC + 1);

  logic [SLOTS_W-1:0] left_q;
  logic [CYC_W-1:0]   cyc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q <= '0;
      cyc_q  <= '0;
    end else if (load_i) begin
      left_q <= slots_i;
      cyc_q  <= '0;
    end else if (run_i && left_q != '0) begin
      if (cyc_q == CYC_W'(SLOT_CYC - 1)) begin
        cyc_q  <= '0;
        left_q <= left_q - 1'b1;
      end else begin
        cyc_q <= cyc_q + 1'b1;
      end
    end
  end

  assign expired_o = (left_q == '0);

  a_r5_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && left_q == '0) |=> left_q == '0);
  a_r5_slot_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_q < CYC_W'(SLOT_CYC));
endmodule

// File: rtl/collision_backoff_ctrl.sv
module collision_backoff_ctrl
  import cbo_pkg::*;
#(
  parameter int unsigned JAM_CYC       = 8,
  parameter int unsigned IFG_CYC       = 24,
  parameter int unsigned SLOT_CYC      = 128,
  parameter int unsigned ATTEMPT_LIMIT = 16,
  parameter int unsigned BACKOFF_CAP   = 10,
  parameter int unsigned LFSR_W        = 16,
  localparam int unsigned ATT_W = $clog2(ATTEMPT_LIMIT + 1),
  localparam int unsigned CNT_W = $clog2(((JAM_CYC > IFG_CYC) ? JAM_CYC : IFG_CYC) + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   serial_mode_i,
  input  logic                   half_duplex_i,
  input  logic                   col_i,
  input  logic                   frame_done_i,
  input  logic                   bus_reset_req_i,
  input  logic                   bus_reset_done_i,
  output logic                   tx_allow_o,
  output logic                   jam_o,
  output logic                   retry_o,
  output logic                   fail_o,
  output logic                   bus_reset_o,
  output logic                   done_o,
  output logic [ATT_W-1:0]       attempt_o,
  output logic [BACKOFF_CAP-1:0] backoff_slots_o
);
  cbo_state_e state_q, state_d;
  logic [CNT_W-1:0]       cnt_q;
  logic [ATT_W-1:0]       attempt_q;
  logic [BACKOFF_CAP-1:0] slots_q, slots_pick, rnd;
  logic                   wait_over;
  logic                   col_active;

  cbo_lfsr #(.WIDTH(LFSR_W), .OUT_W(BACKOFF_CAP)) u_lfsr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rnd_o (rnd)
  );

  cbo_backoff_pick #(.ATT_W(ATT_W), .CAP(BACKOFF_CAP)) u_pick (
    .attempt_i(attempt_q),
    .rnd_i    (rnd),
    .slots_o  (slots_pick)
  );

  cbo_slot_timer #(.SLOT_CYC(SLOT_CYC), .SLOTS_W(BACKOFF_CAP)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (state_q == ST_CALC),
    .slots_i  (slots_pick),
    .run_i    (state_q == ST_WAIT),
    .expired_o(wait_over)
  );

  assign col_active = col_i && half_duplex_i && !serial_mode_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (serial_mode_i && bus_reset_req_i) state_d = ST_BUSRST;
        else if (col_active)                  state_d = ST_JAM;
        else if (frame_done_i)                state_d = ST_IFG;
      end
      ST_JAM:    if (cnt_q == CNT_W'(JAM_CYC - 1)) state_d = ST_INCR;
      ST_INCR:   state_d = (attempt_q + 1'b1 >= ATT_W'(ATTEMPT_LIMIT)) ? ST_GIVEUP : ST_CALC;
      ST_CALC:   state_d = ST_WAIT;
      ST_WAIT:   if (wait_over) state_d = ST_RETRY;
      ST_RETRY:  state_d = ST_IDLE;
      ST_GIVEUP: state_d = ST_IDLE;
      ST_IFG:    if (cnt_q == CNT_W'(IFG_CYC - 1)) state_d = ST_IDLE;
      ST_BUSRST: if (bus_reset_done_i) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      attempt_q <= '0;
      slots_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_d != state_q) cnt_q <= '0;
      else                    cnt_q <= cnt_q + 1'b1;
      if (state_q == ST_INCR) attempt_q <= attempt_q + 1'b1;
      else if (state_q == ST_GIVEUP) attempt_q <= '0;
      else if (state_q == ST_IDLE && state_d inside {ST_IFG, ST_BUSRST}) attempt_q <= '0;
      if (state_q == ST_CALC) slots_q <= slots_pick;
    end
  end

  assign tx_allow_o      = (state_q == ST_IDLE);
  assign jam_o           = (state_q == ST_JAM);
  assign retry_o         = (state_q == ST_RETRY);
  assign fail_o          = (state_q == ST_GIVEUP);
  assign bus_reset_o     = (state_q == ST_BUSRST);
  assign done_o          = retry_o || fail_o
                        || (state_q == ST_IFG && cnt_q == CNT_W'(IFG_CYC - 1))
                        || (bus_reset_o && bus_reset_done_i);
  assign attempt_o       = attempt_q;
  assign backoff_slots_o = slots_q;

  a_r3_attempt_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(jam_o) |=> attempt_o == $past(attempt_o) + 1'b1);
  a_r4_backoff_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retry_o && attempt_o < ATT_W'(BACKOFF_CAP)) |-> (backoff_slots_o >> attempt_o) == '0);
  a_r5_single_outcome: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({retry_o, fail_o, jam_o, bus_reset_o}));
  a_r5_retry_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retry_o |-> done_o ##1 tx_allow_o);
  a_r6_fail_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |=> attempt_o == '0);
  a_r6_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    attempt_o <= ATT_W'(ATTEMPT_LIMIT));
  a_r8_full_duplex: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_allow_o && !half_duplex_i && !bus_reset_req_i) |=> !jam_o);
  a_r2_jam_blocks_tx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jam_o |-> !tx_allow_o);
endmodule

// File: tb/collision_backoff_ctrl_tb.sv
module collision_backoff_ctrl_tb;
  localparam int SLOT = 4;
  localparam int JAM  = 8;
  localparam int IFG  = 24;
  localparam int LIM  = 16;
  localparam int CAP  = 10;

  logic clk = 0, rst_n = 0;
  logic serial_mode = 0, half_duplex = 1, col = 0, frame_done = 0;
  logic br_req = 0, br_done = 0;
  logic tx_allow, jam, retry, fail, bus_reset, done;
  logic [4:0] attempt;
  logic [CAP-1:0] slots;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  collision_backoff_ctrl #(.JAM_CYC(JAM), .IFG_CYC(IFG), .SLOT_CYC(SLOT),
                           .ATTEMPT_LIMIT(LIM), .BACKOFF_CAP(CAP)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .serial_mode_i(serial_mode), .half_duplex_i(half_duplex),
    .col_i(col), .frame_done_i(frame_done), .bus_reset_req_i(br_req),
    .bus_reset_done_i(br_done), .tx_allow_o(tx_allow), .jam_o(jam), .retry_o(retry),
    .fail_o(fail), .bus_reset_o(bus_reset), .done_o(done), .attempt_o(attempt),
    .backoff_slots_o(slots));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse_col();
    col = 1; @(negedge clk); col = 0;
  endtask

  // one Ethernet collision; expect_fail selects the give-up outcome
  task automatic run_collision(input bit expect_fail, input bit verbose);
    int jcnt = 0, n = 0, a0, r, k;
    a0 = attempt;
    pulse_col();
    while (jam && jcnt < 100) begin jcnt++; @(negedge clk); end
    if (verbose || jcnt != JAM) chk(jcnt == JAM, "R2 jam length", jcnt, JAM);
    while (!retry && !fail && n < 5000) begin
      n++;
      if (n == 1 && verbose) chk(attempt == a0, "R3 attempt held first cycle", attempt, a0);
      if (n == 2 && verbose) chk(attempt == a0 + 1, "R3 attempt incremented", attempt, a0 + 1);
      @(negedge clk);
    end
    if (expect_fail) begin
      chk(fail && done, "R6 fail with done", fail, 1);
      chk(n == 1, "R6 fail timing", n, 1);
      @(negedge clk);
      chk(attempt == 0, "R6 attempt cleared", attempt, 0);
      chk(tx_allow, "R6 idle after fail", tx_allow, 1);
    end else begin
      r = slots;
      k = (a0 + 1 < CAP) ? a0 + 1 : CAP;
      if (verbose || r >= (1 << k)) chk(r < (1 << k), "R4 backoff range", r, (1 << k) - 1);
      if (verbose || n != 3 + r * SLOT || !done) begin
        chk(retry && done, "R5 retry with done", done, 1);
        chk(n == 3 + r * SLOT, "R5 retry timing", n, 3 + r * SLOT);
      end
      @(negedge clk);
      if (verbose) begin
        chk(!retry, "R5 retry single cycle", retry, 0);
        chk(tx_allow, "R5 idle after retry", tx_allow, 1);
      end
    end
  endtask

  task automatic t_reset();
    chk(tx_allow, "R1 tx_allow", tx_allow, 1);
    chk(attempt == 0, "R1 attempt", attempt, 0);
    chk({jam, retry, fail, bus_reset, done} == 0, "R1 outputs low",
        {jam, retry, fail, bus_reset, done}, 0);
  endtask

  task automatic t_ifg(input bit col_inside);
    int low = 0;
    frame_done = 1; @(negedge clk); frame_done = 0;
    while (!tx_allow && low < 200) begin
      low++;
      if (col_inside && low == 5) col = 1;
      if (col_inside && low == 6) col = 0;
      if (jam) chk(0, "R10 jam during gap", 1, 0);
      if (low == IFG) chk(done, "R7 done in last gap cycle", done, 1);
      @(negedge clk);
    end
    chk(low == IFG, col_inside ? "R10 gap length with collision" : "R7 gap length", low, IFG);
    chk(attempt == 0, "R7 attempt cleared", attempt, 0);
    repeat (3) begin
      chk(!jam && tx_allow, "R10 collision not latched", jam, 0);
      @(negedge clk);
    end
  endtask

  task automatic t_full_duplex();
    half_duplex = 0;
    pulse_col();
    repeat (3) begin
      chk(!jam && tx_allow, "R8 full duplex ignores collision", jam, 0);
      @(negedge clk);
    end
    half_duplex = 1;
  endtask

  task automatic t_serial();
    int hold = 0;
    serial_mode = 1;
    pulse_col();
    chk(!jam && tx_allow, "R9 serial mode ignores collision", jam, 0);
    br_req = 1; @(negedge clk); br_req = 0;
    chk(bus_reset && !tx_allow, "R9 bus reset entered", bus_reset, 1);
    repeat (4) begin
      @(negedge clk);
      if (bus_reset && !done) hold++;
    end
    chk(hold == 4, "R9 bus reset held", hold, 4);
    br_done = 1; #1;
    chk(done && bus_reset, "R9 done on ack", done, 1);
    @(negedge clk); br_done = 0;
    chk(!bus_reset && tx_allow, "R9 back to idle", bus_reset, 0);
    chk(attempt == 0, "R9 attempt cleared", attempt, 0);
    serial_mode = 0;
  endtask

  task automatic t_limit();
    for (int i = 1; i < LIM; i++) run_collision(0, 0);
    chk(attempt == LIM - 1, "R6 attempts before limit", attempt, LIM - 1);
    run_collision(1, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    run_collision(0, 1);
    run_collision(0, 1);
    t_ifg(0);
    run_collision(0, 1);
    t_serial();
    t_full_duplex();
    t_ifg(1);
    t_limit();
    run_collision(0, 1);
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule